// File: doc/BRIEF.md
# Sixteen-bit parallel host bus master

This block is a bus master. It takes read and write requests from inside the chip and carries each one out as a single transfer on an external 16-bit parallel bus. Typical slaves are asynchronous SRAM, flash that is only read, FIFOs, and programmable-logic devices.

A sub-mode field selects one of three bus formats. In the multiplexed format, the shared AD lines first carry the low address, marked by ALE, and then carry the data. In the split format, a separate set of address lines carries the address, and ALE works as an active-low enable. In the FIFO format there is no address phase; the slave's full and empty flags can hold the transfer back.

The block has no dedicated chip-select output. Software places active-low select bits in the upper address, and the block drives those bits unchanged on the upper address lines while a transfer runs. The sub-configuration register clears itself whenever the top-level interface mode leaves host-bus operation.

Top module: `hb16_master`

## Requirements
- R1: The sub-configuration word has this layout: [1:0] sub-mode (0 multiplexed, 1 split, 2 FIFO, 3 behaves as multiplexed), [5:4] read wait states, [7:6] write wait states, [15:8] maximum wait, [16] read strobe active high, [17] write strobe active high, [18] empty-flag enable, [19] full-flag enable. All other bits read as zero. A write is accepted only while `if_mode` equals 3. While `if_mode` is any other value, the register is held at zero, so its contents are lost after leaving host-bus mode.
- R2: When no transfer is in progress, both strobes sit at their inactive level, `ad_oe` is 0, `ext_addr_hi` is all ones, and ALE is low (high in split mode). `req_ready` is 1 exactly when the block is idle and `if_mode` equals 3.
- R3: A multiplexed transfer begins with one cycle in which ALE is high and AD drives `req_addr[15:0]`. Throughout the transfer, `ext_addr_hi` carries `req_addr[27:16]` as active-low device selects.
- R4: A split transfer has no ALE pulse. ALE stays low for the whole transfer, and `ext_addr_lo` carries `req_addr[15:0]`.
- R5: A strobe stays active for (wait states + 1) cycles. Reads use the read wait-state field and writes use the write wait-state field.
- R6: During a write strobe, AD drives the write data with `ad_oe` set. During a read strobe, AD is released, and the value on `ad_in` in the last strobe cycle is returned. Writes and error responses return zero data. Only the strobe that matches the request direction is ever active.
- R7: `rsp_valid` pulses for exactly one cycle, in the cycle after the last strobe cycle. `req_ready` stays low from acceptance until that cycle.
- R8: Each strobe's active level is high when its active-high bit is set and low otherwise.
- R9: In FIFO mode, a write is held back while `fifo_full` and the full-flag enable are both set. A read is held back while `fifo_empty` and the empty-flag enable are both set. The strobe starts in the cycle after the blocking flag is seen low. A flag whose enable is clear has no effect.
- R10: A held-back transfer with a non-zero maximum wait M ends without any strobe. Its response, with `rsp_err` set, arrives M+1 cycles after acceptance. With M equal to 0, the block waits for as long as the flag stays set.
- R11: In FIFO mode, ALE stays low and `ext_addr_lo` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_mode | input | 2 | Top-level interface mode; 3 selects host-bus operation |
| cfg_wr_en | input | 1 | Write strobe for the sub-configuration word |
| cfg_wr_data | input | 32 | Sub-configuration write value |
| cfg_rd_data | output | 32 | Current sub-configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_addr | input | 28 | Request address; bits 27:16 are device selects |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Transfer ended by flag timeout |
| ad_out | output | 16 | Shared address/data output value |
| ad_oe | output | 1 | Output enable for AD; 0 means tri-stated |
| ad_in | input | 16 | Value sampled from the AD pins |
| ext_addr_hi | output | 12 | Upper address / active-low device selects |
| ext_addr_lo | output | 16 | Low address lines in split mode |
| ale | output | 1 | Address latch enable |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| fifo_full | input | 1 | Slave FIFO full flag |
| fifo_empty | input | 1 | Slave FIFO empty flag |

## Verification
Every result is counted from the acceptance edge. In multiplexed mode, the strobe begins in the second cycle after acceptance and the response arrives wait+3 cycles after acceptance. In split and unblocked FIFO modes, each of those comes one cycle earlier. A blocked FIFO transfer starts its strobe in the cycle after the flag drops, and a timeout response arrives M+1 cycles after acceptance. The bench samples every cycle at the falling edge, from acceptance to the response. For each cycle it records the strobe, ALE, AD and address values. It then compares the strobe count, the index of the first strobe cycle and the index of the response cycle with values it works out from the configuration it has written.

// File: rtl/hb16_pkg.sv
package hb16_pkg;

    localparam int unsigned AD_W    = 16;
    localparam int unsigned WS_W    = 2;
    localparam int unsigned MAXW_W  = 8;
    localparam int unsigned CFG_W   = 32;

    typedef enum logic [1:0] {
        SUB_MUX  = 2'd0,
        SUB_SEP  = 2'd1,
        SUB_FIFO = 2'd2,
        SUB_ALT  = 2'd3
    } sub_mode_e;

    typedef struct packed {
        logic              full_en;
        logic              empty_en;
        logic              wr_high;
        logic              rd_high;
        logic [MAXW_W-1:0] max_wait;
        logic [WS_W-1:0]   wr_ws;
        logic [WS_W-1:0]   rd_ws;
        sub_mode_e         mode;
    } hb_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALE   = 2'd1,
        ST_STRB  = 2'd2,
        ST_FWAIT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic      busy;
        logic      ale_phase;
        logic      rd_act;
        logic      wr_act;
        sub_mode_e mode;
    } bus_ctl_t;

    function automatic logic [CFG_W-1:0] cfg_to_word(hb_cfg_t c);
        logic [CFG_W-1:0] w;
        w        = '0;
        w[1:0]   = c.mode;
        w[5:4]   = c.rd_ws;
        w[7:6]   = c.wr_ws;
        w[15:8]  = c.max_wait;
        w[16]    = c.rd_high;
        w[17]    = c.wr_high;
        w[18]    = c.empty_en;
        w[19]    = c.full_en;
        return w;
    endfunction

    function automatic logic addr_muxed(sub_mode_e m);
        return (m == SUB_MUX) || (m == SUB_ALT);
    endfunction

    function automatic logic fifo_blocked(logic wr, logic full, logic empty,
                                          logic fen, logic een);
        return wr ? (fen && full) : (een && empty);
    endfunction

endpackage

// File: rtl/hb16_cfg_regs.sv
module hb16_cfg_regs
    import hb16_pkg::*;
#(
    parameter int unsigned       MODE_W  = 2,
    parameter logic [MODE_W-1:0] HB_CODE = 2'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] if_mode,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output hb_cfg_t           cfg_o,
    output logic [CFG_W-1:0]  rd_data,
    output logic              hb_sel
);

    hb_cfg_t cfg_q;
    logic    unused_bits;

    assign hb_sel      = (if_mode == HB_CODE);
    assign unused_bits = ^{wr_data[31:20], wr_data[3:2]};

    always_ff @(posedge clk) begin
        if (rst || !hb_sel) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.mode     <= sub_mode_e'(wr_data[1:0]);
            cfg_q.rd_ws    <= wr_data[5:4];
            cfg_q.wr_ws    <= wr_data[7:6];
            cfg_q.max_wait <= wr_data[15:8];
            cfg_q.rd_high  <= wr_data[16];
            cfg_q.wr_high  <= wr_data[17];
            cfg_q.empty_en <= wr_data[18];
            cfg_q.full_en  <= wr_data[19];
        end
    end

    assign cfg_o   = cfg_q;
    assign rd_data = cfg_to_word(cfg_q);

    // R1: re-entering host-bus mode always finds a cleared register
    a_r1_clean_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_sel) |-> (rd_data == '0));

    // R1: writes outside host-bus mode leave no trace
    a_r1_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (!hb_sel && wr_en) |=> (rd_data == '0) || hb_sel);

endmodule

// File: rtl/hb16_seq.sv
module hb16_seq
    import hb16_pkg::*;
#(
    parameter int unsigned ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_sel,
    input  hb_cfg_t           cfg,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [AD_W-1:0]   rsp_rdata,
    output logic              rsp_err,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [AD_W-1:0]   ad_in,
    output bus_ctl_t          ctl,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [AD_W-1:0]   xfer_wdata
);

    seq_state_e        state_q;
    logic [WS_W-1:0]   cnt_q;
    logic [WS_W-1:0]   ws_q;
    logic [MAXW_W-1:0] wcnt_q;
    logic [MAXW_W-1:0] max_q;
    logic [ADDR_W-1:0] addr_q;
    logic [AD_W-1:0]   wdata_q;
    logic              write_q;
    logic              fen_q;
    logic              een_q;
    sub_mode_e         mode_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [AD_W-1:0]   rdata_q;

    logic              accept;
    logic              block_now;
    logic              block_new;
    logic [MAXW_W:0]   wcnt_nxt;
    logic              timeout;
    logic              unused_pol;

    assign unused_pol = ^{cfg.rd_high, cfg.wr_high};

    assign req_ready = hb_sel && (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign block_new = (cfg.mode == SUB_FIFO) &&
                       fifo_blocked(req_write, fifo_full, fifo_empty,
                                    cfg.full_en, cfg.empty_en);
    assign block_now = fifo_blocked(write_q, fifo_full, fifo_empty, fen_q, een_q);
    assign wcnt_nxt  = {1'b0, wcnt_q} + 1'b1;
    assign timeout   = (max_q != '0) && (wcnt_nxt == {1'b0, max_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            ws_q        <= '0;
            wcnt_q      <= '0;
            max_q       <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            write_q     <= 1'b0;
            fen_q       <= 1'b0;
            een_q       <= 1'b0;
            mode_q      <= SUB_MUX;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        mode_q  <= cfg.mode;
                        ws_q    <= req_write ? cfg.wr_ws : cfg.rd_ws;
                        max_q   <= cfg.max_wait;
                        fen_q   <= cfg.full_en;
                        een_q   <= cfg.empty_en;
                        cnt_q   <= '0;
                        wcnt_q  <= '0;
                        if (addr_muxed(cfg.mode)) begin
                            state_q <= ST_ALE;
                        end else if (block_new) begin
                            state_q <= ST_FWAIT;
                        end else begin
                            state_q <= ST_STRB;
                        end
                    end
                end
                ST_ALE: begin
                    state_q <= ST_STRB;
                end
                ST_STRB: begin
                    if (cnt_q == ws_q) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rdata_q     <= write_q ? '0 : ad_in;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FWAIT: begin
                    if (!block_now) begin
                        state_q <= ST_STRB;
                    end else if (timeout) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= 1'b1;
                        rdata_q     <= '0;
                    end else begin
                        wcnt_q <= wcnt_nxt[MAXW_W-1:0];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_err       = rsp_err_q;
    assign rsp_rdata     = rdata_q;
    assign ctl.busy      = (state_q != ST_IDLE);
    assign ctl.ale_phase = (state_q == ST_ALE);
    assign ctl.rd_act    = (state_q == ST_STRB) && !write_q;
    assign ctl.wr_act    = (state_q == ST_STRB) && write_q;
    assign ctl.mode      = (state_q != ST_IDLE) ? mode_q : cfg.mode;
    assign xfer_addr     = addr_q;
    assign xfer_wdata    = wdata_q;

    // R7: the completion pulse lasts a single cycle
    a_r7_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R7: no new request is taken until the response has been issued
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R10: error responses come only from flag-blocked FIFO transfers
    a_r10_err_fifo_only: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && mode_q == SUB_FIFO && rsp_rdata == '0));

    // R10: a zero maximum wait never times out
    a_r10_wait_forever: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FWAIT && max_q == '0) |=> !rsp_err);

    // R5: strobe counter never passes the latched wait count
    a_r5_strobe_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STRB && cnt_q != ws_q) |=> (state_q == ST_STRB));

endmodule

// File: rtl/hb16_pins.sv
module hb16_pins
    import hb16_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    localparam int unsigned HI_W  = ADDR_W - AD_W
) (
    input  bus_ctl_t          ctl,
    input  logic              rd_high,
    input  logic              wr_high,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [AD_W-1:0]   xfer_wdata,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ext_addr_hi,
    output logic [AD_W-1:0]   ext_addr_lo,
    output logic              ale,
    output logic              rd_strobe,
    output logic              wr_strobe
);

    always_comb begin
        ad_oe  = ctl.ale_phase || ctl.wr_act;
        ad_out = '0;
        if (ctl.ale_phase) begin
            ad_out = xfer_addr[AD_W-1:0];
        end else if (ctl.wr_act) begin
            ad_out = xfer_wdata;
        end
    end

    always_comb begin
        ext_addr_hi = '1;
        ext_addr_lo = '0;
        if (ctl.busy) begin
            ext_addr_hi = xfer_addr[ADDR_W-1:AD_W];
            if (ctl.mode == SUB_SEP) begin
                ext_addr_lo = xfer_addr[AD_W-1:0];
            end
        end
    end

    assign ale       = (ctl.mode == SUB_SEP) ? !ctl.busy : ctl.ale_phase;
    assign rd_strobe = ctl.rd_act ? rd_high : !rd_high;
    assign wr_strobe = ctl.wr_act ? wr_high : !wr_high;

endmodule

// File: rtl/hb16_master.sv
module hb16_master
    import hb16_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 28,
    parameter int unsigned       MODE_W  = 2,
    parameter logic [MODE_W-1:0] HB_CODE = 2'd3,
    localparam int unsigned      HI_W    = ADDR_W - AD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] if_mode,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [AD_W-1:0]   rsp_rdata,
    output logic              rsp_err,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_in,
    output logic [HI_W-1:0]   ext_addr_hi,
    output logic [AD_W-1:0]   ext_addr_lo,
    output logic              ale,
    output logic              rd_strobe,
    output logic              wr_strobe,
    input  logic              fifo_full,
    input  logic              fifo_empty
);

    hb_cfg_t           cfg;
    logic              hb_sel;
    bus_ctl_t          ctl;
    logic [ADDR_W-1:0] xfer_addr;
    logic [AD_W-1:0]   xfer_wdata;

    hb16_cfg_regs #(.MODE_W(MODE_W), .HB_CODE(HB_CODE)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .if_mode (if_mode),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg),
        .rd_data (cfg_rd_data),
        .hb_sel  (hb_sel)
    );

    hb16_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .hb_sel     (hb_sel),
        .cfg        (cfg),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .ad_in      (ad_in),
        .ctl        (ctl),
        .xfer_addr  (xfer_addr),
        .xfer_wdata (xfer_wdata)
    );

    hb16_pins #(.ADDR_W(ADDR_W)) pins_i (
        .ctl         (ctl),
        .rd_high     (cfg.rd_high),
        .wr_high     (cfg.wr_high),
        .xfer_addr   (xfer_addr),
        .xfer_wdata  (xfer_wdata),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ext_addr_hi (ext_addr_hi),
        .ext_addr_lo (ext_addr_lo),
        .ale         (ale),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe)
    );

    // R6: never both strobes at their active level
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !((rd_strobe == cfg.rd_high) && (wr_strobe == cfg.wr_high)));

    // R6: AD is released whenever the read strobe is active
    a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe == cfg.rd_high) |-> !ad_oe);

    // R3: the address phase raises ALE and drives AD
    a_r3_ale_drives: assert property (@(posedge clk) disable iff (rst)
        ctl.ale_phase |-> (ale && ad_oe));

    // R2: an idle, ready block deselects every device
    a_r2_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ext_addr_hi == '1 && !ad_oe));

endmodule

// File: tb/hb16_master_tb_top.sv
`timescale 1ns/1ps
module hb16_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  if_mode = 2'd3;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] slave_data = 16'h1234;
    logic [11:0] ext_addr_hi;
    logic [15:0] ext_addr_lo;
    logic        ale, rd_strobe, wr_strobe;
    logic        fifo_full = 1'b0;
    logic        fifo_empty = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int c_mode = 0, c_rws = 0, c_wws = 0, c_max = 0;
    bit c_rh = 0, c_wh = 0, c_een = 0, c_fen = 0;

    always #2.5 clk = ~clk;

    hb16_master dut_i (
        .clk(clk), .rst(rst), .if_mode(if_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(slave_data),
        .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo),
        .ale(ale), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(int m, int rw, int ww, int mx,
                                             bit rh, bit wh, bit een, bit fen);
        logic [31:0] w;
        w = '0;
        w[1:0] = m[1:0]; w[5:4] = rw[1:0]; w[7:6] = ww[1:0]; w[15:8] = mx[7:0];
        w[16] = rh; w[17] = wh; w[18] = een; w[19] = fen;
        return w;
    endfunction

    task automatic cfg_set(input int m, input int rw, input int ww, input int mx,
                           input bit rh, input bit wh, input bit een, input bit fen);
        @(negedge clk);
        cfg_wr_data = cfg_word(m, rw, ww, mx, rh, wh, een, fen);
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        c_mode = m; c_rws = rw; c_wws = ww; c_max = mx;
        c_rh = rh; c_wh = wh; c_een = een; c_fen = fen;
    endtask

    task automatic idle_check(input string tag);
        chk(rd_strobe == !c_rh && wr_strobe == !c_wh, "R8", {tag, " idle strobes"},
            {rd_strobe, wr_strobe}, {!c_rh, !c_wh});
        chk(!ad_oe && ext_addr_hi == 12'hFFF, "R2", {tag, " idle bus"},
            {ad_oe, ext_addr_hi}, {1'b0, 12'hFFF});
        chk(ale == (c_mode == 1), "R2", {tag, " idle ale"}, ale, (c_mode == 1));
    endtask

    // rel: index of the cycle during which the FIFO flags are dropped (-1: never)
    task automatic xfer(input bit wr, input logic [27:0] a, input logic [15:0] wd,
                        input int rel);
        int  ws, exp_rsp, exp_first, idx, rsp_at, n_str, first_seen;
        bit  mux, stall, exp_err, rd_on, wr_on;
        bit  bad_other, bad_data, bad_ale, bad_lo, bad_hi, bad_rdy;
        logic [15:0] exp_data;
        ws = wr ? c_wws : c_rws;
        mux = (c_mode == 0 || c_mode == 3);
        stall = (c_mode == 2) && (wr ? (c_fen && fifo_full) : (c_een && fifo_empty));
        exp_err = 1'b0; exp_first = 0;
        if (stall) begin
            if (c_max != 0 && (rel < 0 || c_max <= rel)) begin
                exp_err = 1'b1; exp_rsp = c_max + 1;
            end else begin
                exp_first = rel + 1; exp_rsp = rel + 2 + ws;
            end
        end else begin
            exp_first = mux ? 2 : 1;
            exp_rsp = exp_first + ws + 1;
        end
        exp_data = (wr || exp_err) ? 16'h0 : slave_data;
        idx = 1; rsp_at = 0; n_str = 0; first_seen = 0;
        bad_other = 0; bad_data = 0; bad_ale = 0; bad_lo = 0; bad_hi = 0; bad_rdy = 0;

        chk(req_ready, "R2", "ready before request", req_ready, 1);
        req_addr = a; req_wdata = wd; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (idx < 3000) begin
            if (rsp_valid) begin
                rsp_at = idx;
                break;
            end
            rd_on = (rd_strobe == c_rh);
            wr_on = (wr_strobe == c_wh);
            if (wr ? rd_on : wr_on) bad_other = 1;
            if (wr ? wr_on : rd_on) begin
                n_str++;
                if (first_seen == 0) first_seen = idx;
                if (wr && !(ad_oe && ad_out == wd)) bad_data = 1;
                if (!wr && ad_oe) bad_data = 1;
            end
            if (mux) begin
                if (ale != (idx == 1)) bad_ale = 1;
                if (idx == 1 && !(ad_oe && ad_out == a[15:0])) bad_ale = 1;
            end else begin
                if (ale) bad_ale = 1;
                if (c_mode == 1 && ext_addr_lo != a[15:0]) bad_lo = 1;
                if (c_mode == 2 && ext_addr_lo != 16'h0) bad_lo = 1;
            end
            if (ext_addr_hi != a[27:16]) bad_hi = 1;
            if (req_ready) bad_rdy = 1;
            if (idx == rel) begin
                fifo_full = 1'b0;
                fifo_empty = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
        chk(rsp_at == exp_rsp, stall ? (exp_err ? "R10" : "R9") : "R7",
            "response cycle", rsp_at, exp_rsp);
        chk(n_str == (exp_err ? 0 : ws + 1), "R5", "strobe cycles", n_str,
            exp_err ? 0 : ws + 1);
        if (stall && !exp_err)
            chk(first_seen == exp_first, "R9", "first strobe cycle", first_seen, exp_first);
        chk(!bad_other && !bad_data, "R6", "strobe direction/AD", {bad_other, bad_data}, 0);
        chk(!bad_ale, mux ? "R3" : (c_mode == 1 ? "R4" : "R11"), "ALE/address phase",
            bad_ale, 0);
        chk(!bad_lo, c_mode == 2 ? "R11" : "R4", "low address lines", bad_lo, 0);
        chk(!bad_hi, "R3", "upper address selects", bad_hi, 0);
        chk(!bad_rdy, "R7", "ready low while busy", bad_rdy, 0);
        chk(rsp_rdata == exp_data, "R6", "response data", rsp_rdata, exp_data);
        chk(rsp_err == exp_err, "R10", "error flag", rsp_err, exp_err);
        @(negedge clk);
        chk(!rsp_valid, "R7", "single-cycle response", rsp_valid, 0);
        idle_check("post");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(cfg_rd_data == 32'h0, "R1", "reset cfg", cfg_rd_data, 0);
        chk(!rsp_valid && req_ready, "R2", "reset handshake", {rsp_valid, req_ready}, 2'b01);
        idle_check("reset");

        // R1: readback, clear on leaving, blocked writes
        cfg_set(2, 3, 1, 8'hA5, 1, 0, 1, 1);
        chk(cfg_rd_data == (32'hFFFF_FFFF & 32'h000F_FFF3 & cfg_word(2, 3, 1, 8'hA5, 1, 0, 1, 1)),
            "R1", "cfg readback", cfg_rd_data, cfg_word(2, 3, 1, 8'hA5, 1, 0, 1, 1));
        @(negedge clk);
        cfg_wr_data = 32'hFFFF_FFFF; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(cfg_rd_data == 32'h000F_FFF3, "R1", "reserved bits read zero", cfg_rd_data,
            32'h000F_FFF3);
        if_mode = 2'd1;
        @(negedge clk);
        chk(cfg_rd_data == 32'h0, "R1", "cleared on mode change", cfg_rd_data, 0);
        chk(!req_ready, "R2", "not ready outside host-bus mode", req_ready, 0);
        cfg_wr_data = 32'h0003_0011; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if_mode = 2'd3;
        @(negedge clk);
        chk(cfg_rd_data == 32'h0, "R1", "write outside mode ignored", cfg_rd_data, 0);
        c_mode = 0; c_rws = 0; c_wws = 0; c_max = 0; c_rh = 0; c_wh = 0; c_een = 0; c_fen = 0;

        // directed: muxed with all-zero config, read and write
        slave_data = 16'hBEEF;
        xfer(1'b0, 28'h6801234, 16'h0, -1);
        xfer(1'b1, 28'h6404321, 16'hCAFE, -1);

        // directed: split mode, long waits, active-high strobes
        cfg_set(1, 3, 2, 0, 1, 1, 0, 0);
        idle_check("split");
        xfer(1'b0, 28'hA5A55AA, 16'h0, -1);
        xfer(1'b1, 28'h123FEDC, 16'h7777, -1);

        // FIFO: flag with enable clear has no effect
        cfg_set(2, 1, 0, 0, 0, 0, 0, 0);
        fifo_full = 1'b1; fifo_empty = 1'b1;
        xfer(1'b1, 28'h0000000, 16'h5151, -1);
        xfer(1'b0, 28'h0000000, 16'h0, -1);
        fifo_full = 1'b0; fifo_empty = 1'b0;

        // FIFO: write blocked by full, times out after 3 cycles
        cfg_set(2, 0, 1, 3, 0, 0, 0, 1);
        fifo_full = 1'b1;
        xfer(1'b1, 28'hFF00000, 16'h9999, -1);
        fifo_full = 1'b0;
        // FIFO: full flag drops before the limit
        fifo_full = 1'b1;
        xfer(1'b1, 28'hFF00000, 16'h3C3C, 2);

        // FIFO: read blocked by empty, zero max waits until release
        cfg_set(2, 2, 0, 0, 0, 0, 1, 0);
        fifo_empty = 1'b1;
        slave_data = 16'h0F0F;
        xfer(1'b0, 28'h0ABCDEF, 16'h0, 12);
        // empty flag does not hold back a write
        fifo_empty = 1'b1;
        xfer(1'b1, 28'h0ABCDEF, 16'h2468, -1);
        fifo_empty = 1'b0;

        // constrained random
        for (int i = 0; i < 60; i++) begin
            int m;
            m = int'($urandom_range(0, 3));
            cfg_set(m, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 0,
                    bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 0, 0);
            slave_data = 16'($urandom);
            fifo_full = bit'($urandom_range(0, 1));
            xfer(bit'($urandom_range(0, 1)), 28'($urandom), 16'($urandom), -1);
            fifo_full = 1'b0;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule